// File: doc/BRIEF.md
# Watchdog Timer with Early Warning Interrupt

This block is a free-running watchdog counter on the system clock. Software picks one of four timeout spans with a 2-bit select. It must restart the count with a one-cycle kick strobe before the span runs out. A fixed number of cycles before the span ends, the block raises a warning interrupt, so software gets a last chance to act. If the span ends without a kick, the block drives a reset request pulse of fixed length. It also records the event in a sticky cause flag, which the system reads after it comes back up.

The counter sits at zero while the block is disabled. It restarts on a kick, on any change of the interval select, and on its own timeout. The cause flag is cleared only by power-on reset or by a software clear strobe. The spans, the warning lead and the pulse length are parameters. The defaults are spans of 2^12, 2^15, 2^18 and 2^21 cycles, a 512-cycle lead and a 4-cycle pulse.

Top module: `wdt_early_irq`

## Requirements
- R1: While `por_n` is low and after it is released, `early_irq`, `rst_req` and `wd_flag` are 0.
- R2: Select code k (00, 01, 10, 11 for k = 0..3) sets the span to 2^(BASE_LOG2 + STEP_LOG2*k) cycles. Without a kick, `rst_req` rises exactly that many clock edges after the edge that restarted the count.
- R3: `early_irq` rises exactly EARLY_CYCLES clock edges before the edge where `rst_req` rises.
- R4: `rst_req` stays high for exactly PULSE_CYCLES cycles per timeout. It rises on the edge that ends the span.
- R5: A timeout sets `wd_flag`. The flag stays set until `flag_clr` is pulsed, and the watchdog's own reset request does not clear it. If a timeout and `flag_clr` fall in the same cycle, the flag ends up set.
- R6: A `kick` while enabled restarts the count from zero and clears `early_irq`. Kicking more often than the span prevents both the interrupt and the reset request.
- R7: Once raised, `early_irq` stays high until `irq_clr`, a kick, a select change, a disable or the timeout clears it.
- R8: Any change of `ivl_sel` restarts the count from zero and clears `early_irq`. The new span then applies in full.
- R9: While `wd_en` is low the count is held at zero, `early_irq` is cleared and no reset request starts. `wd_flag` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Active-low power-on reset |
| wd_en | input | 1 | Watchdog enable |
| ivl_sel | input | 2 | Timeout span select |
| kick | input | 1 | One-cycle software restart strobe |
| irq_clr | input | 1 | Clears the warning interrupt |
| flag_clr | input | 1 | Software clear of the cause flag |
| early_irq | output | 1 | Warning interrupt, high until cleared |
| rst_req | output | 1 | Fixed-length reset request pulse |
| wd_flag | output | 1 | Sticky watchdog-reset cause flag |

## Verification
The bench measures the distance from a restart to the reset request for several select codes. A design off by one in its terminal compare would miss these counts by a cycle. It also measures the distance from the interrupt to the reset request, and a warning computed from the wrong end of the span would show up there. A clear strobe placed in the exact cycle of a timeout checks that setting the flag wins. A select change made while the interrupt is high checks that the count truly restarts rather than carrying over into the new span. A disable window must show neither an interrupt nor a pulse, and the flag must survive it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Length in cycles of the span picked by one select code.
  function automatic logic [63:0] wdt_span(input int unsigned base_log2,
                                           input int unsigned step_log2,
                                           input int unsigned code);
    return 64'd1 << (base_log2 + step_log2 * code);
  endfunction

  // Counter width that holds the longest span minus one.
  function automatic int unsigned wdt_cnt_width(input int unsigned base_log2,
                                                input int unsigned step_log2);
    return base_log2 + 3 * step_log2 + 1;
  endfunction

  typedef struct packed {
    logic warn;
    logic tmo;
  } wdt_evt_t;

endpackage

// File: rtl/wdt_limit.sv
module wdt_limit #(
  parameter int unsigned BASE_LOG2    = 12,
  parameter int unsigned STEP_LOG2    = 3,
  parameter int unsigned EARLY_CYCLES = 512,
  parameter int unsigned CW           = 22
) (
  input  logic [1:0]    ivl_sel,
  output logic [CW-1:0] last_cnt,
  output logic [CW-1:0] warn_cnt
);
  localparam int unsigned NSEL = 4;

  logic [CW-1:0] last_tbl [NSEL];
  logic [CW-1:0] warn_tbl [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_span
    localparam logic [63:0] SPAN = wdt_pkg::wdt_span(BASE_LOG2, STEP_LOG2, g);
    assign last_tbl[g] = CW'(SPAN - 64'd1);
    assign warn_tbl[g] = CW'(SPAN - 64'(EARLY_CYCLES) - 64'd1);
  end

  assign last_cnt = last_tbl[ivl_sel];
  assign warn_cnt = warn_tbl[ivl_sel];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CW = 22
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            wd_en,
  input  logic            restart,
  input  logic [CW-1:0]   last_cnt,
  input  logic [CW-1:0]   warn_cnt,
  output wdt_pkg::wdt_evt_t evt
);
  logic [CW-1:0] cnt_q;
  logic          run;

  assign run      = wd_en && !restart;
  assign evt.tmo  = run && (cnt_q == last_cnt);
  assign evt.warn = run && (cnt_q == warn_cnt);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 cnt_q <= '0;
    else if (!run || evt.tmo)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic start,
  output logic rst_req
);
  localparam int unsigned PW = $clog2(PULSE_CYCLES + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              left_q <= '0;
    else if (start)          left_q <= PW'(PULSE_CYCLES);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign rst_req = (left_q != '0);
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
  input  logic            clk,
  input  logic            por_n,
  input  logic            wd_en,
  input  logic            restart,
  input  wdt_pkg::wdt_evt_t evt,
  input  logic            irq_clr,
  input  logic            flag_clr,
  output logic            early_irq,
  output logic            wd_flag
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                          early_irq <= 1'b0;
    else if (!wd_en || restart || evt.tmo) early_irq <= 1'b0;
    else if (evt.warn)                   early_irq <= 1'b1;
    else if (irq_clr)                    early_irq <= 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        wd_flag <= 1'b0;
    else if (evt.tmo)  wd_flag <= 1'b1;
    else if (flag_clr) wd_flag <= 1'b0;
  end
endmodule

// File: rtl/wdt_early_irq.sv
module wdt_early_irq #(
  parameter int unsigned BASE_LOG2    = 12,
  parameter int unsigned STEP_LOG2    = 3,
  parameter int unsigned EARLY_CYCLES = 512,
  parameter int unsigned PULSE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       wd_en,
  input  logic [1:0] ivl_sel,
  input  logic       kick,
  input  logic       irq_clr,
  input  logic       flag_clr,
  output logic       early_irq,
  output logic       rst_req,
  output logic       wd_flag
);
  localparam int unsigned CW = wdt_pkg::wdt_cnt_width(BASE_LOG2, STEP_LOG2);

  logic [1:0]        sel_q;
  logic              sel_chg;
  logic              restart;
  logic [CW-1:0]     last_cnt;
  logic [CW-1:0]     warn_cnt;
  wdt_pkg::wdt_evt_t evt;
  logic              warn_evt;
  logic              tmo_evt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sel_q <= 2'b00;
    else        sel_q <= ivl_sel;
  end

  assign sel_chg  = (ivl_sel != sel_q);
  assign restart  = kick || sel_chg;
  assign warn_evt = evt.warn;
  assign tmo_evt  = evt.tmo;

  wdt_limit #(
    .BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2),
    .EARLY_CYCLES(EARLY_CYCLES), .CW(CW)
  ) u_limit (
    .ivl_sel(ivl_sel), .last_cnt(last_cnt), .warn_cnt(warn_cnt)
  );

  wdt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .por_n(por_n), .wd_en(wd_en), .restart(restart),
    .last_cnt(last_cnt), .warn_cnt(warn_cnt), .evt(evt)
  );

  wdt_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk(clk), .por_n(por_n), .start(tmo_evt), .rst_req(rst_req)
  );

  wdt_status u_status (
    .clk(clk), .por_n(por_n), .wd_en(wd_en), .restart(restart), .evt(evt),
    .irq_clr(irq_clr), .flag_clr(flag_clr),
    .early_irq(early_irq), .wd_flag(wd_flag)
  );
endmodule

// File: rtl/wdt_early_irq_chk.sv
module wdt_early_irq_chk #(
  parameter int unsigned EARLY_CYCLES = 512,
  parameter int unsigned PULSE_CYCLES = 4
) (
  input logic clk,
  input logic por_n,
  input logic wd_en,
  input logic kick,
  input logic flag_clr,
  input logic early_irq,
  input logic rst_req,
  input logic wd_flag,
  input logic warn_evt,
  input logic tmo_evt
);
  logic [31:0] lead_q;
  logic [31:0] hi_run_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lead_q   <= '0;
      hi_run_q <= '0;
    end else begin
      if (warn_evt)             lead_q <= 32'd1;
      else if (lead_q != '1)    lead_q <= lead_q + 32'd1;
      hi_run_q <= rst_req ? hi_run_q + 32'd1 : 32'd0;
    end
  end

  a_r3_warn_lead: assert property (@(posedge clk) disable iff (!por_n)
    tmo_evt |-> (lead_q == 32'(EARLY_CYCLES)));

  a_r4_pulse_starts: assert property (@(posedge clk) disable iff (!por_n)
    tmo_evt |=> rst_req);

  a_r4_pulse_len: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_req) |-> (hi_run_q == 32'(PULSE_CYCLES)));

  a_r5_flag_set: assert property (@(posedge clk) disable iff (!por_n)
    tmo_evt |=> wd_flag);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (wd_flag && !flag_clr) |=> wd_flag);

  a_r6_kick_clears: assert property (@(posedge clk) disable iff (!por_n)
    (wd_en && kick) |=> !early_irq);

  a_r9_off_quiet: assert property (@(posedge clk) disable iff (!por_n)
    !wd_en |=> !early_irq);
endmodule

bind wdt_early_irq wdt_early_irq_chk #(
  .EARLY_CYCLES(EARLY_CYCLES), .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (
  .clk(clk), .por_n(por_n), .wd_en(wd_en), .kick(kick), .flag_clr(flag_clr),
  .early_irq(early_irq), .rst_req(rst_req), .wd_flag(wd_flag),
  .warn_evt(warn_evt), .tmo_evt(tmo_evt)
);

// File: tb/wdt_early_irq_tb.sv
module wdt_early_irq_tb;
  localparam int BASE = 6, STEP = 1, EARLY = 16, PULSE = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por_n = 1'b0, wd_en = 1'b0, kick = 1'b0, irq_clr = 1'b0, flag_clr = 1'b0;
  logic [1:0] ivl_sel = 2'b00;
  logic early_irq, rst_req, wd_flag;

  int checks = 0, errors = 0, cyc = 0;
  int m_cnt = 0, m_pulse = 0;
  bit m_irq = 0, m_flag = 0, m_rs, m_to;
  logic [1:0] m_psel = 2'b00;
  int k_rst, k_irq, seen;
  bit first_irq;

  wdt_early_irq #(.BASE_LOG2(BASE), .STEP_LOG2(STEP),
                  .EARLY_CYCLES(EARLY), .PULSE_CYCLES(PULSE)) u_dut (
    .clk(clk), .por_n(por_n), .wd_en(wd_en), .ivl_sel(ivl_sel), .kick(kick),
    .irq_clr(irq_clr), .flag_clr(flag_clr),
    .early_irq(early_irq), .rst_req(rst_req), .wd_flag(wd_flag));

  function automatic int span(input logic [1:0] s);
    return 1 << (BASE + STEP * int'(s));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference, advanced on each rising edge.
  always @(posedge clk) begin
    cyc++;
    if (!por_n) begin
      m_cnt = 0; m_pulse = 0; m_irq = 0; m_flag = 0; m_psel = 2'b00;
    end else begin
      m_rs = kick || (ivl_sel != m_psel);
      m_to = 0;
      if (m_pulse > 0) m_pulse--;
      if (!wd_en || m_rs) begin
        m_cnt = 0; m_irq = 0;
      end else if (m_cnt == span(ivl_sel) - 1) begin
        m_cnt = 0; m_irq = 0; m_to = 1;
      end else begin
        m_cnt++;
        if (m_cnt == span(ivl_sel) - EARLY) m_irq = 1;
        else if (irq_clr) m_irq = 0;
      end
      if (m_to) begin m_pulse = PULSE; m_flag = 1; end
      else if (flag_clr) m_flag = 0;
      m_psel = ivl_sel;
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual %0d expected 0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (por_n) begin
      chk("R3 R7 early_irq vs model", int'(early_irq), int'(m_irq));
      chk("R4 rst_req vs model", int'(rst_req), int'(m_pulse > 0));
      chk("R5 wd_flag vs model", int'(wd_flag), int'(m_flag));
    end
  end

  // Restart through a kick or a select change, then time irq and reset.
  task automatic measure(input logic [1:0] s, input bit by_kick);
    if (by_kick) kick = 1'b1;
    ivl_sel = s;
    @(negedge clk);
    kick = 1'b0;
    first_irq = early_irq;
    k_rst = 0; k_irq = -1;
    while (!rst_req && k_rst < 5000) begin
      @(negedge clk);
      k_rst++;
      if (early_irq && k_irq < 0) k_irq = k_rst;
    end
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (rst_req && n < 100) begin n++; @(negedge clk); end
  endtask

  int n;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", int'(early_irq), 0);
    chk("R1 rst_req in reset", int'(rst_req), 0);
    chk("R1 flag in reset", int'(wd_flag), 0);
    por_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs after release", int'({early_irq, rst_req, wd_flag}), 0);

    wd_en = 1'b1;
    measure(2'b00, 1'b1);
    chk("R2 span code 00", k_rst, span(2'b00));
    chk("R3 lead code 00", k_rst - k_irq, EARLY);
    pulse_len(n);
    chk("R4 pulse length", n, PULSE);
    chk("R5 flag after timeout", int'(wd_flag), 1);

    measure(2'b11, 1'b0);
    chk("R2 R8 span code 11", k_rst, span(2'b11));
    chk("R3 lead code 11", k_rst - k_irq, EARLY);
    pulse_len(n);
    chk("R4 pulse length code 11", n, PULSE);

    measure(2'b01, 1'b0);
    chk("R2 R8 span code 01", k_rst, span(2'b01));
    pulse_len(n);

    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk("R5 flag cleared by software", int'(wd_flag), 0);
    repeat (10) @(negedge clk);
    chk("R5 flag stays clear", int'(wd_flag), 0);

    ivl_sel = 2'b00; @(negedge clk);
    seen = 0;
    for (int i = 0; i < 6; i++) begin
      kick = 1'b1; @(negedge clk); kick = 1'b0;
      for (int j = 0; j < 40; j++) begin
        @(negedge clk);
        if (early_irq || rst_req) seen++;
      end
    end
    chk("R6 regular kicks keep quiet", seen, 0);

    kick = 1'b1; @(negedge clk); kick = 1'b0;
    repeat (span(2'b00) - EARLY + 3) @(negedge clk);
    chk("R7 irq raised", int'(early_irq), 1);
    repeat (5) @(negedge clk);
    chk("R7 irq held", int'(early_irq), 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk("R7 irq cleared by irq_clr", int'(early_irq), 0);

    kick = 1'b1; @(negedge clk); kick = 1'b0;
    repeat (span(2'b00) - EARLY + 2) @(negedge clk);
    chk("R6 irq up before kick", int'(early_irq), 1);
    kick = 1'b1; @(negedge clk); kick = 1'b0;
    chk("R6 kick clears irq", int'(early_irq), 0);

    repeat (span(2'b00) - EARLY + 2) @(negedge clk);
    chk("R8 irq up before select change", int'(early_irq), 1);
    measure(2'b01, 1'b0);
    chk("R8 select change clears irq", int'(first_irq), 0);
    chk("R8 full new span", k_rst, span(2'b01));
    pulse_len(n);

    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    kick = 1'b1; ivl_sel = 2'b00; @(negedge clk); kick = 1'b0;
    repeat (span(2'b00) - 1) @(negedge clk);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk("R5 timeout with clear sets flag", int'(wd_flag), 1);
    chk("R4 pulse present", int'(rst_req), 1);
    pulse_len(n);

    kick = 1'b1; @(negedge clk); kick = 1'b0;
    repeat (span(2'b00) - EARLY + 2) @(negedge clk);
    wd_en = 1'b0; @(negedge clk);
    chk("R9 disable clears irq", int'(early_irq), 0);
    seen = 0;
    for (int j = 0; j < 300; j++) begin
      @(negedge clk);
      if (early_irq || rst_req) seen++;
    end
    chk("R9 no activity while off", seen, 0);
    chk("R9 flag kept while off", int'(wd_flag), 1);
    wd_en = 1'b1;
    repeat (span(2'b00) + 10) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule